// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block behaves like a small serial EEPROM on a two-wire bus. It runs entirely on a fast system clock. It samples the bus clock and data lines as plain inputs and drives the data line only through an active-high pull-low enable, which the pad ring turns into an open-drain output. Every START restarts reception of a control byte. The upper nibble of that byte must match a fixed device code. The next three bits are ignored, and the last bit picks a write (0) or a read (1).

A write sends a word address and then any number of data bytes. Each data byte lands in a 256-entry byte array at the current address, and the address then steps up by one, wrapping from 255 to 0. A STOP that ends a write containing at least one data byte starts an internal programming timer. While that timer runs, the slave ignores its own address, so a master finds out that programming is finished by polling until it gets an ACK. A read returns bytes from the current address onward and advances the address after each byte. It stops when the master answers a byte with NACK.

The address pointer persists between transfers. A read that does not first set an address therefore continues from wherever the previous transfer left the pointer.

Top module: `ser_eeprom_slave`

## Requirements
- R1: A control byte whose bits 7:4 equal 4'b1010 is acknowledged whatever bits 3:1 hold, provided no programming period is running. Acknowledging means holding SDA low throughout the ninth SCL high phase.
- R2: A control byte whose bits 7:4 differ from 4'b1010 is not acknowledged. The slave then leaves SDA released and ignores every byte until the next START, and those bytes change no stored data.
- R3: Bit 0 of an acknowledged control byte selects the transfer direction: 0 starts a write and 1 starts a read.
- R4: In a write, the first byte after the control byte loads the address pointer. Each later byte is acknowledged and stored at the pointer, and the pointer then increments, wrapping from 255 to 0.
- R5: In a read, the slave drives the byte at the pointer MSB first, one bit per SCL period, and increments the pointer. It carries on after a master ACK (SDA low on the ninth clock). After a NACK (SDA high) it releases SDA and stays silent.
- R6: A STOP that follows at least one stored data byte starts a programming period of BUSY_CLKS system clocks. Control bytes whose decision falls inside that period are not acknowledged, and the same control byte is acknowledged once the period has ended.
- R7: A STOP that follows only a control byte and an address byte, with no data byte, starts no programming period.
- R8: A START (SDA falling while SCL is high) is recognised at any point, including part-way through a byte or directly after an acknowledge. Reception of a new control byte begins after it.
- R9: The slave changes its pull-low enable only while SCL is low. It releases SDA after every acknowledge clock so that the transmitter can drive the next bit.
- R10: After reset SDA is released, the slave is idle, every array byte reads as 0x00 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (resolved wired-AND value) |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
The assertions check four things on every clock. The slave must never start pulling SDA while the synchronised SCL is high. SDA must stay released in idle and during the master-acknowledge bit. A control acknowledge can occur only with a matching device code and no programming period in progress. Every programming period must last exactly BUSY_CLKS clocks. The bench scenarios cover what only whole transfers can show: the bytes read back after writes with address wrap, the don't-care control bits, the NACK and later ACK of polling, the silence after a foreign device code, and a START that cuts a byte short.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // waiting for START
    ST_CTRL,   // shifting in control byte
    ST_CACK,   // acknowledging control byte
    ST_ADDR,   // shifting in word address
    ST_AACK,   // acknowledging word address
    ST_WDAT,   // shifting in a data byte
    ST_WACK,   // acknowledging a data byte
    ST_TX,     // driving a read byte
    ST_MACK    // listening for master ACK/NACK
  } ee_state_e;

  function automatic logic code_hit(input logic [7:0] ctrl, input logic [3:0] code);
    return ctrl[7:4] == code;
  endfunction
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // STAGES synchroniser flops plus one history flop per line
  logic [STAGES:0] scl_sr;
  logic [STAGES:0] sda_sr;
  logic            scl_old;
  logic            sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[STAGES-1:0], scl_i};
      sda_sr <= {sda_sr[STAGES-1:0], sda_i};
    end
  end

  assign scl_lvl = scl_sr[STAGES-1];
  assign sda_lvl = sda_sr[STAGES-1];
  assign scl_old = scl_sr[STAGES];
  assign sda_old = sda_sr[STAGES];

  assign scl_rise  = scl_lvl & ~scl_old;
  assign scl_fall  = ~scl_lvl & scl_old;
  assign start_det = scl_lvl & scl_old & sda_old & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_old & ~sda_old & sda_lvl;
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (go)           left <= CW'(CYCLES);
    else if (left != '0)   left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/ee_word_array.sv
module ee_word_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cells[g] <= '0;
      else if (we && waddr == AW'(g))        cells[g] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave
  import ee_pkg::*;
#(
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         AW          = 8,
  parameter int         BUSY_CLKS   = 5000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int BW = 8;
  localparam logic [3:0] LAST_BIT = 4'(BW);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic busy, prog_go;

  ee_state_e     state;
  logic [3:0]    bitcnt;
  logic [BW-1:0] shreg;
  logic [AW-1:0] ptr;
  logic          pull;
  logic          dirty;    // data byte stored since last START
  logic          rd_mode;
  logic          more;     // master acknowledged the last read byte

  logic          mem_we;
  logic [BW-1:0] rdata;

  ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  assign prog_go = stop_det & dirty;

  ee_prog_timer #(.CYCLES(BUSY_CLKS)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (prog_go),
    .busy (busy)
  );

  assign mem_we = (state == ST_WDAT) && scl_fall && (bitcnt == LAST_BIT) &&
                  !start_det && !stop_det;

  ee_word_array #(.AW(AW), .DW(BW)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .waddr(ptr),
    .wdata(shreg),
    .raddr(ptr),
    .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      pull    <= 1'b0;
      dirty   <= 1'b0;
      rd_mode <= 1'b0;
      more    <= 1'b0;
    end else if (start_det) begin
      state  <= ST_CTRL;
      bitcnt <= '0;
      pull   <= 1'b0;
      dirty  <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      pull  <= 1'b0;
      dirty <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_CTRL, ST_ADDR, ST_WDAT: begin
          if (scl_rise && bitcnt != LAST_BIT) begin
            shreg  <= {shreg[BW-2:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == LAST_BIT) begin
            bitcnt <= '0;
            if (state == ST_CTRL) begin
              if (code_hit(shreg, DEV_CODE) && !busy) begin
                pull    <= 1'b1;
                rd_mode <= shreg[0];
                state   <= ST_CACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_ADDR) begin
              pull  <= 1'b1;
              ptr   <= shreg[AW-1:0];
              state <= ST_AACK;
            end else begin
              pull  <= 1'b1;
              ptr   <= ptr + 1'b1;
              dirty <= 1'b1;
              state <= ST_WACK;
            end
          end
        end
        ST_CACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              shreg  <= rdata;
              pull   <= ~rdata[BW-1];
              bitcnt <= '0;
              state  <= ST_TX;
            end else begin
              pull  <= 1'b0;
              state <= ST_ADDR;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            pull  <= 1'b0;
            state <= ST_WDAT;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              pull  <= 1'b0;
              ptr   <= ptr + 1'b1;
              state <= ST_MACK;
            end else begin
              shreg <= {shreg[BW-2:0], 1'b0};
              pull  <= ~shreg[BW-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            more <= ~sda_lvl;
          end else if (scl_fall) begin
            if (more) begin
              shreg  <= rdata;
              pull   <= ~rdata[BW-1];
              bitcnt <= '0;
              state  <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_pull_o = pull;
endmodule

// File: rtl/ee_slave_chk.sv
module ee_slave_chk
  import ee_pkg::*;
#(
  parameter logic [3:0] DEV_CODE  = 4'b1010,
  parameter int         AW        = 8,
  parameter int         BUSY_CLKS = 5000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_pull_o,
  input logic          scl_lvl,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] ptr,
  input logic [7:0]    shreg,
  input ee_state_e     state
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  AST_CODE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_CACK) |-> shreg[7:4] == DEV_CODE); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_o); // R2

  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sda_pull_o && state == ST_WACK)); // R4

  AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MACK) |-> !sda_pull_o); // R5

  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CACK) |-> !busy); // R6

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == BUSY_CLKS); // R6

  AST_NO_PULL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !sda_pull_o) |=> !sda_pull_o); // R9

  AST_PTR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $past(state == ST_IDLE)) |-> $stable(ptr)); // R5
endmodule

bind ser_eeprom_slave ee_slave_chk #(
  .DEV_CODE (DEV_CODE),
  .AW       (AW),
  .BUSY_CLKS(BUSY_CLKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_pull_o(sda_pull_o),
  .scl_lvl   (scl_lvl),
  .busy      (busy),
  .mem_we    (mem_we),
  .ptr       (ptr),
  .shreg     (shreg),
  .state     (state)
);

// File: tb/test_ser_eeprom_slave.sv
module test_ser_eeprom_slave;
  localparam int BUSY = 2000;
  localparam int Q    = 8;
  localparam int P_DEAD = 0, P_CTRL = 1, P_ADDR = 2, P_DATA = 3, P_READ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pull;
  logic sda_line;

  assign sda_line = sda_m & ~pull;

  ser_eeprom_slave #(.BUSY_CLKS(BUSY)) i_ser_eeprom_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_pull_o(pull)
  );

  always #5 clk = ~clk;

  int    n_cmp = 0, n_bad = 0, cyc = 0, hi_cnt = 0;
  logic  exp_pull = 1'b0;
  string cur_req = "R10";
  int    mem_m [256];
  int    ptr_m = 0, phase_m = P_DEAD, busy_end = 0;
  bit    wrote_m = 0;

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference drive level compared on every clock of a settled SCL high phase
  always @(negedge clk) begin
    cyc++;
    if (scl_m) hi_cnt++; else hi_cnt = 0;
    if (rst_n && hi_cnt >= 4) cmp("R9", pull, exp_pull, {"sda drive during ", cur_req});
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL all watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clock_bit(input bit b, output bit seen);
    half(); sda_m = b; half(); scl_m = 1'b1; half(); seen = sda_line; half(); scl_m = 1'b0;
  endtask

  task automatic do_start();
    exp_pull = 1'b0;
    half(); sda_m = 1'b1; half(); scl_m = 1'b1; half(); sda_m = 1'b0; half(); scl_m = 1'b0;
    phase_m = P_CTRL; wrote_m = 0;
  endtask

  task automatic do_stop();
    exp_pull = 1'b0;
    half(); sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
    if (wrote_m) busy_end = cyc + BUSY + 4;
    wrote_m = 0; phase_m = P_DEAD;
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    bit s; bit ack_exp;
    cur_req = req; exp_pull = 1'b0;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    ack_exp = 0;
    case (phase_m)
      P_CTRL: begin
        ack_exp = (b[7:4] == 4'hA) && (cyc >= busy_end);
        phase_m = ack_exp ? (b[0] ? P_READ : P_ADDR) : P_DEAD;
      end
      P_ADDR: begin ack_exp = 1; ptr_m = b; phase_m = P_DATA; end
      P_DATA: begin ack_exp = 1; mem_m[ptr_m] = b; ptr_m = (ptr_m + 1) % 256; wrote_m = 1; end
      default: ack_exp = 0;
    endcase
    exp_pull = ack_exp;
    clock_bit(1'b1, s);
    exp_pull = 1'b0;
    cmp(req, s, !ack_exp, "acknowledge level");
  endtask

  task automatic recv_byte(input bit mack, input string req);
    bit s; logic [7:0] e; logic [7:0] got;
    cur_req = req; e = mem_m[ptr_m]; got = '0;
    for (int i = 7; i >= 0; i--) begin
      exp_pull = !e[i];
      clock_bit(1'b1, s);
      got[i] = s;
    end
    exp_pull = 1'b0;
    cmp(req, got, e, "read byte");
    ptr_m = (ptr_m + 1) % 256;
    clock_bit(!mack, s);
    if (!mack) phase_m = P_DEAD;
  endtask

  task automatic wait_idle();
    while (cyc < busy_end + 20) half();
  endtask

  initial begin
    bit s;
    for (int i = 0; i < 256; i++) mem_m[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    half();
    cmp("R10", pull, 0, "released after reset");

    // write three bytes at 0x10 (R3 write direction, R4 storage)
    do_start(); send_byte(8'hA0, "R3"); send_byte(8'h10, "R4");
    send_byte(8'h11, "R4"); send_byte(8'h22, "R4"); send_byte(8'h33, "R4");
    do_stop();
    // poll during programming: expect NACK (R6)
    do_start(); send_byte(8'hA1, "R6"); do_stop();
    wait_idle();
    // poll after programming: ACK, current-address read at 0x13 (R6, R5)
    do_start(); send_byte(8'hA1, "R6"); recv_byte(0, "R5"); do_stop();
    // random read with repeated START (R8, R5, R3 read direction)
    do_start(); send_byte(8'hA0, "R4"); send_byte(8'h10, "R4");
    do_start(); send_byte(8'hA1, "R3");
    recv_byte(1, "R5"); recv_byte(1, "R5"); recv_byte(0, "R5"); do_stop();
    // address-only write then STOP: no programming period (R7)
    do_start(); send_byte(8'hA0, "R7"); send_byte(8'h40, "R7"); do_stop();
    // don't-care bits set, write wrapping past 0xFF (R1, R4)
    do_start(); send_byte(8'hAE, "R1"); send_byte(8'hFE, "R4");
    send_byte(8'h05, "R4"); send_byte(8'h06, "R4"); send_byte(8'h07, "R4");
    do_stop();
    // foreign device code: silent for the whole transfer (R2)
    do_start(); send_byte(8'hB0, "R2"); send_byte(8'h20, "R2"); send_byte(8'h99, "R2");
    do_stop();
    wait_idle();
    do_start(); send_byte(8'hA0, "R2"); send_byte(8'h20, "R2");
    do_start(); send_byte(8'hA1, "R2"); recv_byte(0, "R2"); do_stop();
    // read across the wrap with don't-care bits in a read (R4, R1)
    do_start(); send_byte(8'hA0, "R4"); send_byte(8'hFE, "R4");
    do_start(); send_byte(8'hA5, "R1");
    recv_byte(1, "R4"); recv_byte(1, "R4"); recv_byte(0, "R4"); do_stop();
    // START part-way through a byte (R8)
    do_start(); cur_req = "R8";
    clock_bit(1'b1, s); clock_bit(1'b0, s); clock_bit(1'b1, s); clock_bit(1'b0, s);
    do_start(); send_byte(8'hA1, "R8"); recv_byte(0, "R8"); do_stop();
    // never-written location reads as zero (R10)
    do_start(); send_byte(8'hA0, "R10"); send_byte(8'h80, "R10");
    do_start(); send_byte(8'hA1, "R10"); recv_byte(0, "R10"); do_stop();
    half(); half();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule